// File: doc/BRIEF.md
# SPI Word Shifter with Little-Endian Byte Ordering

This block moves one serial word per transfer between a parallel register and the SPI data lines. A pulse on `start` captures the TX word, the bit count and the ordering controls. The block then presents one bit at a time on `mosi`. An external clock generator supplies single-cycle strobes for the rising and falling bus edges. The block samples `miso` on each rising strobe and steps to the next bit on each falling strobe. A one-cycle `done` pulse follows the falling strobe of the last bit.

Without reordering, the word is shifted from its top valid bit downward, or from bit 0 upward when LSB-first is selected. With reordering in effect, bytes go out lowest byte first, and each byte is still sent MSB first. Reordering applies only to MSB-first transfers of 16, 24 or 32 bits, and only while variable-clock mode is off. Each received bit is stored at the same position its transmitted bit came from, so a loopback returns the valid part of the TX word.

Top module: `spi_byte_shifter`

## Requirements
- R1: After reset `busy`, `done`, `mosi` and `rx_word` are all 0, and `mosi` is 0 whenever no transfer is active.
- R2: `len` gives the bit count; 0 or any value above 32 means 32. In plain MSB-first mode, bit k of the transfer (k = 0 first) is `tx_word[len-1-k]`.
- R3: With `lsb_first`=1, bit k is `tx_word[k]`, and `reorder_en` has no effect.
- R4: Reordering is in effect when `lsb_first`=0, `reorder_en`=1, `varclk_en`=0 and the count is 32. Bit k is then `tx_word[8*(k/8) + 7 - k%8]`, so the byte order is [7:0], [15:8], [23:16], [31:24], each byte MSB first.
- R5: With reordering and a count of 24, three bytes go out in the order [7:0], [15:8], [23:16] by the R4 formula. `tx_word[31:24]` has no effect on `mosi`, and `rx_word[31:24]` reads 0.
- R6: With reordering and a count of 16, the bytes go out in the order [7:0], then [15:8], by the R4 formula.
- R7: For a count other than 16, 24 or 32, `reorder_en` is ignored and the plain order of R2 applies.
- R8: While `varclk_en`=1, `reorder_en` is ignored and the plain order of R2 applies.
- R9: The `miso` value sampled on the rising strobe of bit k is stored in `rx_word` at the same bit position that bit k was sent from. `rx_word` is cleared at start, and bits not covered by the transfer stay 0.
- R10: `done` is high for exactly one cycle, in the cycle after the clock edge that registers the last bit's falling strobe. `busy` is low in that cycle.
- R11: A `start` while `busy` is high is ignored: the running transfer keeps its captured word and settings.
- R12: A rising and a falling strobe in the same cycle first sample `miso` for the current bit and then advance to the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| tx_word | input | 32 | Parallel word to send |
| len | input | 6 | Bit count; 0 or >32 means 32 |
| lsb_first | input | 1 | 1 = shift from bit 0 upward |
| reorder_en | input | 1 | Request lowest-byte-first ordering |
| varclk_en | input | 1 | Variable-clock mode active; disables reordering |
| rise_stb | input | 1 | Rising bus-edge strobe: sample `miso` |
| fall_stb | input | 1 | Falling bus-edge strobe: advance bit |
| miso | input | 1 | Serial data in |
| mosi | output | 1 | Serial data out |
| rx_word | output | 32 | Assembled received word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at end of transfer |

## Verification
The rising and falling strobes can land in the same cycle. The sample must then use the bit position from before the counter steps. A second collision is `start` arriving while a transfer is running. The bench drives some transfers with both strobes merged into one cycle. It gives each bit a distinct `miso` value, so that a sample landing at the advanced position shows up as a wrong `rx_word`. It also fires a second `start` with a different word mid-transfer and checks that the `mosi` stream and the received word still match the first capture.

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int W  = 32,
  parameter int LW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  tx_word,
  input  logic [LW-1:0] len,
  input  logic          lsb_first,
  input  logic          reorder_en,
  input  logic          varclk_en,
  input  logic          rise_stb,
  input  logic          fall_stb,
  input  logic          miso,
  output logic          mosi,
  output logic [W-1:0]  rx_word,
  output logic          busy,
  output logic          done
);
  localparam int IW = $clog2(W);

  logic [W-1:0]  tx_q, rx_q;
  logic [LW-1:0] cnt, len_q, len_eff, pos;
  logic          lsb_q, reord_q, reord_ok, last;
  logic [IW-1:0] idx;

  assign len_eff  = (len == '0 || len > LW'(W)) ? LW'(W) : len;
  assign reord_ok = !lsb_first && reorder_en && !varclk_en &&
                    (len_eff == LW'(16) || len_eff == LW'(24) || len_eff == LW'(32));

  always_comb begin
    if (reord_q)    pos = {cnt[LW-1:3], ~cnt[2:0]};
    else if (lsb_q) pos = cnt;
    else            pos = len_q - LW'(1) - cnt;
  end
  assign idx  = pos[IW-1:0];
  assign last = (cnt == len_q - LW'(1));

  assign mosi    = busy & tx_q[idx];
  assign rx_word = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      len_q   <= LW'(W);
      lsb_q   <= 1'b0;
      reord_q <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          cnt     <= '0;
          tx_q    <= tx_word;
          rx_q    <= '0;
          len_q   <= len_eff;
          lsb_q   <= lsb_first;
          reord_q <= reord_ok;
        end
      end else begin
        if (rise_stb) rx_q[idx] <= miso;
        if (fall_stb) begin
          if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + LW'(1);
          end
        end
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < len_q));

  a_r11_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(tx_q) && $stable(len_q) && $stable(reord_q) && $stable(lsb_q)));

  a_r9_rx_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(rx_word));

  a_r4_reorder_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (lsb_first || varclk_en)) |=> !reord_q);
endmodule

// File: tb/sim_spi_byte_shifter.sv
module sim_spi_byte_shifter;
  logic        clk = 0, rst_n = 0;
  logic        start = 0, lsb_first = 0, reorder_en = 0, varclk_en = 0;
  logic        rise_stb = 0, fall_stb = 0, miso = 0;
  logic [31:0] tx_word = 0;
  logic [5:0]  len = 0;
  wire         mosi, busy, done;
  wire  [31:0] rx_word;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_byte_shifter u0 (.clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .len(len), .lsb_first(lsb_first), .reorder_en(reorder_en), .varclk_en(varclk_en),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .miso(miso), .mosi(mosi),
    .rx_word(rx_word), .busy(busy), .done(done));

  function automatic int eff_len(int l);
    return (l == 0 || l > 32) ? 32 : l;
  endfunction

  function automatic int exp_pos(int k, int n, bit lsb, bit ro, bit vc);
    bit reord = !lsb && ro && !vc && (n == 16 || n == 24 || n == 32);
    if (reord) return (k / 8) * 8 + 7 - (k % 8);
    if (lsb) return k;
    return n - 1 - k;
  endfunction

  function automatic logic [31:0] low_mask(int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // merged: rise and fall strobes in one cycle; restart_at: bit index at which
  // a second start with another word is fired (-1 = none)
  task automatic xfer(string req, logic [31:0] tx, int l, bit lsb, bit ro, bit vc,
                      logic [31:0] rsrc, bit merged, int restart_at);
    int n = eff_len(l);
    int bad = 0;
    logic [31:0] exp_rx = 0;
    @(negedge clk);
    tx_word = tx; len = 6'(l); lsb_first = lsb; reorder_en = ro; varclk_en = vc;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < n; k++) begin
      int p = exp_pos(k, n, lsb, ro, vc);
      if (mosi !== tx[p]) bad++;
      if (busy !== 1'b1 || done !== 1'b0) bad++;
      miso = rsrc[p];
      exp_rx[p] = rsrc[p];
      if (k == restart_at) begin
        start = 1; tx_word = ~tx; lsb_first = ~lsb; len = 6'd8;
      end
      if (merged) begin
        rise_stb = 1; fall_stb = 1;
        @(negedge clk);
        rise_stb = 0; fall_stb = 0; start = 0;
      end else begin
        rise_stb = 1;
        @(negedge clk);
        rise_stb = 0; start = 0;
        fall_stb = 1;
        @(negedge clk);
        fall_stb = 0;
      end
    end
    check({req, " mosi stream mismatches"}, 32'(bad), 32'd0);
    check({req, " R10 done pulse"}, {30'd0, busy, done}, 32'h1);
    check({req, " R9 rx word"}, rx_word, exp_rx & low_mask(n));
    @(negedge clk);
    check({req, " R10 done cleared"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=150000", cycles);
        summary();
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {rx_word[30:0], busy}, 32'd0);
    check("R1 reset done/mosi", {30'd0, done, mosi}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle mosi", {31'd0, mosi}, 32'd0);

    xfer("R2 plain 32", 32'hA5C3_0F81, 32, 0, 0, 0, 32'h1234_5678, 0, -1);
    xfer("R2 len0 means 32", 32'h8001_7FFE, 0, 0, 0, 0, 32'hCAFE_F00D, 0, -1);
    xfer("R3 lsb first ignores reorder", 32'h0000_B00B, 16, 1, 1, 0, 32'h0000_5AA5, 0, -1);
    xfer("R4 reorder 32", 32'h1122_3344, 32, 0, 1, 0, 32'hDEAD_BEEF, 0, -1);
    xfer("R5 reorder 24 top ignored", 32'hFF12_3456, 24, 0, 1, 0, 32'hFFAB_CDEF, 0, -1);
    xfer("R5 reorder 24 top changed", 32'h0012_3456, 24, 0, 1, 0, 32'h00AB_CDEF, 0, -1);
    xfer("R6 reorder 16", 32'h0000_C33C, 16, 0, 1, 0, 32'h0000_9696, 0, -1);
    xfer("R7 reorder ignored len 12", 32'h0000_0ABC, 12, 0, 1, 0, 32'h0000_0F0F, 0, -1);
    xfer("R8 reorder ignored varclk", 32'h1122_3344, 32, 0, 1, 1, 32'h0F1E_2D3C, 0, -1);
    xfer("R9 loopback-like 8", 32'h0000_0081, 8, 0, 0, 0, 32'h0000_0081, 0, -1);
    xfer("R11 start while busy", 32'h7654_3210, 32, 0, 1, 0, 32'h0BAD_CAFE, 0, 5);
    xfer("R12 merged strobes reorder", 32'h55AA_33CC, 32, 0, 1, 0, 32'h8421_1248, 1, -1);
    xfer("R12 merged strobes plain", 32'h0001_2345, 20, 0, 0, 0, 32'h000A_5A5A, 1, -1);
    xfer("R2 single bit", 32'h0000_0001, 1, 0, 0, 0, 32'h0000_0001, 0, -1);

    for (int i = 0; i < 40; i++) begin
      int l = int'($urandom_range(0, 40));
      bit lsb = 1'($urandom_range(0, 3) == 0);
      bit ro  = 1'($urandom_range(0, 1));
      bit vc  = 1'($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 1) == 1) l = 8 * int'($urandom_range(2, 4));
      xfer("R9 random mix", $urandom, l, lsb, ro, vc, $urandom, 1'($urandom_range(0, 1)), -1);
    end

    @(negedge clk);
    check("R1 idle after runs mosi", {30'd0, busy, mosi}, 32'd0);
    summary();
  end
endmodule